// File: doc/BRIEF.md
# Self-Timed Byte-Write Memory Controller

This block puts a static-RAM-style bus in front of a 512-byte storage array that behaves like electrically erasable memory. The host drives active-low chip enable, output enable and write enable, a 9-bit address and an 8-bit data path split into an input, an output and an output-drive flag. A read with the block idle returns the addressed byte at once. A write does not finish within its bus cycle. Once a debounced write-enable pulse is accepted, the controller captures the address and the data. It then runs a self-timed sequence on its own: it sets the target byte to the erased value 8'hFF, then programs the captured data.

While that sequence runs, the block is busy. Any read returns a poll pattern in which the top bit is the inverse of the captured data's top bit. The host therefore polls the byte it just wrote until the true value appears. A mode input, sampled when a write is accepted, picks a short or a long phase length. A separate clear input erases every byte, using the same busy and poll behaviour. A write-inhibit input and a power-good input block the start of any new operation.

Top module: `bytewrite_mem_ctrl`

## Requirements
- R1: The block drives data (data_oe=1) exactly when ce_n=0, oe_n=0 and we_n=1. When it is idle, data_out then equals the stored byte at addr. Whenever data_oe=0, data_out is 8'h00.
- R2: After reset every byte of the array reads 8'hFF.
- R3: A write is accepted on the FILTER_CYCLES-th consecutive rising edge at which ce_n and we_n are both low. A shorter low pulse has no effect. One low pulse, however long, starts at most one write.
- R4: Address and data are taken from the bus at the accepting edge. Later changes to the bus do not alter the byte that gets written.
- R5: An accepted write keeps the block busy for exactly 2*P rising edges after the accepting edge. P is SHORT_PHASE or LONG_PHASE. At the last of these edges the target byte takes the captured data, and the block is idle from that edge on.
- R6: While busy, every enabled read returns bit 7 as the inverse of the captured data's bit 7, with bits 6..0 equal to 0.
- R7: long_mode, sampled at the accepting edge, selects P=LONG_PHASE when 1 and P=SHORT_PHASE when 0.
- R8: Write pulses and clear requests that arrive while busy are ignored. They do not change the captured address and data, and they do not alter any byte.
- R9: No write and no chip clear starts at an edge where wr_inhibit=1 or power_good=0.
- R10: A rising edge of clear_req seen while idle, with no write accepted at the same edge, starts a chip clear. The block is busy for 2^ADDR_W edges and polls with bit 7 = 0. Afterwards every byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 9 | Byte address |
| data_in | input | 8 | Write data from host |
| data_out | output | 8 | Read data or poll pattern |
| data_oe | output | 1 | High when the block drives the data bus |
| long_mode | input | 1 | Selects the long write timing |
| clear_req | input | 1 | Chip-clear request, rising-edge triggered |
| wr_inhibit | input | 1 | Blocks the start of writes and clears |
| power_good | input | 1 | Supply-valid indication; low blocks starts |

## Verification
Suppose the phase timer is off by one. The poll pattern would then give way to the stored byte one cycle early or late, and a read of the target address during the last busy cycles would show the error within that write. Suppose instead the captured data or the filter count were wrong. The first read after completion would return the wrong byte, or a glitch would set off an unexpected busy period that shows at the very next enabled read. A faulty clear sweep would leave non-FF bytes, and these appear at the first read of a skipped address after the clear.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ERASE = 2'd1,
        SEQ_PROG  = 2'd2,
        SEQ_SWEEP = 2'd3
    } seq_state_e;
endpackage

// File: rtl/bwm_we_filter.sv
module bwm_we_filter #(
    parameter int FILTER_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_active,
    output logic wr_accept
);
    localparam int CW = $clog2(FILTER_CYCLES + 1);
    localparam logic [CW-1:0] CNT_SAT  = CW'(FILTER_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILTER_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        wr_accept = 1'b0;
        if (wr_active) begin
            wr_accept = (flt_q.cnt == CNT_LAST);
            if (flt_q.cnt != CNT_SAT) begin
                flt_d.cnt = flt_q.cnt + 1'b1;
            end
        end else begin
            flt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '0;
        end else begin
            flt_q <= flt_d;
        end
    end
endmodule

// File: rtl/bwm_seq.sv
module bwm_seq
    import bwm_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 8,
    parameter int SHORT_PHASE = 5000,
    parameter int LONG_PHASE  = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_accept,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              long_mode,
    input  logic              clear_req,
    input  logic              allow,
    output logic              busy,
    output seq_state_e        state,
    output logic [$clog2(LONG_PHASE+1)-1:0] timer,
    output logic [ADDR_W-1:0] sweep,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int TW = $clog2(LONG_PHASE + 1);
    localparam logic [TW-1:0] SHORT_LOAD = TW'(SHORT_PHASE - 1);
    localparam logic [TW-1:0] LONG_LOAD  = TW'(LONG_PHASE - 1);
    localparam logic [ADDR_W-1:0] SWEEP_LAST = '1;
    localparam logic [DATA_W-1:0] ERASED = '1;

    typedef struct packed {
        seq_state_e        st;
        logic [TW-1:0]     tmr;
        logic [TW-1:0]     load;
        logic [ADDR_W-1:0] swp;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
        logic              clr_prev;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        mem_we    = 1'b0;
        mem_waddr = s_q.a;
        mem_wdata = ERASED;
        s_d.clr_prev = clear_req;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (allow && wr_accept) begin
                    s_d.st   = SEQ_ERASE;
                    s_d.a    = wr_addr;
                    s_d.d    = wr_data;
                    s_d.load = long_mode ? LONG_LOAD : SHORT_LOAD;
                    s_d.tmr  = long_mode ? LONG_LOAD : SHORT_LOAD;
                end else if (allow && clear_req && !s_q.clr_prev) begin
                    s_d.st  = SEQ_SWEEP;
                    s_d.swp = '0;
                    s_d.a   = '0;
                    s_d.d   = ERASED;
                end
            end
            SEQ_ERASE: begin
                if (s_q.tmr == '0) begin
                    mem_we  = 1'b1;
                    s_d.st  = SEQ_PROG;
                    s_d.tmr = s_q.load;
                end else begin
                    s_d.tmr = s_q.tmr - 1'b1;
                end
            end
            SEQ_PROG: begin
                if (s_q.tmr == '0) begin
                    mem_we    = 1'b1;
                    mem_wdata = s_q.d;
                    s_d.st    = SEQ_IDLE;
                end else begin
                    s_d.tmr = s_q.tmr - 1'b1;
                end
            end
            SEQ_SWEEP: begin
                mem_we    = 1'b1;
                mem_waddr = s_q.swp;
                if (s_q.swp == SWEEP_LAST) begin
                    s_d.st = SEQ_IDLE;
                end else begin
                    s_d.swp = s_q.swp + 1'b1;
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_IDLE, tmr: '0, load: '0, swp: '0,
                     a: '0, d: '0, clr_prev: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.st != SEQ_IDLE);
    assign state    = s_q.st;
    assign timer    = s_q.tmr;
    assign sweep    = s_q.swp;
    assign lat_addr = s_q.a;
    assign lat_data = s_q.d;
endmodule

// File: rtl/bwm_array.sv
module bwm_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/bytewrite_mem_ctrl.sv
module bytewrite_mem_ctrl
    import bwm_pkg::*;
#(
    parameter int ADDR_W        = 9,
    parameter int DATA_W        = 8,
    parameter int FILTER_CYCLES = 3,
    parameter int SHORT_PHASE   = 5000,
    parameter int LONG_PHASE    = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic              long_mode,
    input  logic              clear_req,
    input  logic              wr_inhibit,
    input  logic              power_good
);
    localparam int TW = $clog2(LONG_PHASE + 1);

    logic              wr_accept;
    logic              busy;
    seq_state_e        seq_state;
    logic [TW-1:0]     seq_timer;
    logic [ADDR_W-1:0] seq_sweep;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] rd_data;
    logic              rd_active;
    logic              allow;

    assign allow = power_good && !wr_inhibit;

    bwm_we_filter #(.FILTER_CYCLES(FILTER_CYCLES)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_active(!ce_n && !we_n),
        .wr_accept(wr_accept)
    );

    bwm_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SHORT_PHASE(SHORT_PHASE), .LONG_PHASE(LONG_PHASE)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_accept(wr_accept),
        .wr_addr  (addr),
        .wr_data  (data_in),
        .long_mode(long_mode),
        .clear_req(clear_req),
        .allow    (allow),
        .busy     (busy),
        .state    (seq_state),
        .timer    (seq_timer),
        .sweep    (seq_sweep),
        .lat_addr (lat_addr),
        .lat_data (lat_data),
        .mem_we   (mem_we),
        .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata)
    );

    bwm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .raddr(addr),
        .rdata(rd_data)
    );

    assign rd_active = !ce_n && !oe_n && we_n;
    assign data_oe   = rd_active;

    always_comb begin
        data_out = '0;
        if (rd_active) begin
            if (busy) begin
                data_out[DATA_W-1] = ~lat_data[DATA_W-1];
            end else begin
                data_out = rd_data;
            end
        end
    end
endmodule

// File: rtl/bwm_chk.sv
module bwm_chk
    import bwm_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int DATA_W     = 8,
    parameter int LONG_PHASE = 25000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_inhibit,
    input logic              power_good,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe,
    input logic              busy,
    input seq_state_e        seq_state,
    input logic [$clog2(LONG_PHASE+1)-1:0] seq_timer,
    input logic [ADDR_W-1:0] seq_sweep,
    input logic [ADDR_W-1:0] lat_addr,
    input logic [DATA_W-1:0] lat_data
);
    localparam int TW = $clog2(LONG_PHASE + 1);

    assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> data_out == '0);

    assert_timer_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_ERASE && $past(seq_state) == SEQ_ERASE)
        |-> seq_timer == TW'($past(seq_timer) - 1'b1));

    assert_poll_pattern_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && data_oe) |-> (data_out[DATA_W-2:0] == '0
                               && data_out[DATA_W-1] == ~lat_data[DATA_W-1]));

    assert_hold_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(lat_addr) && $stable(lat_data)));

    assert_blocked_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (wr_inhibit || !power_good)) |=> !busy);

    assert_sweep_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_SWEEP && $past(seq_state) == SEQ_SWEEP)
        |-> seq_sweep == ADDR_W'($past(seq_sweep) + 1'b1));
endmodule

bind bytewrite_mem_ctrl bwm_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LONG_PHASE(LONG_PHASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_inhibit(wr_inhibit),
    .power_good(power_good),
    .data_out  (data_out),
    .data_oe   (data_oe),
    .busy      (busy),
    .seq_state (seq_state),
    .seq_timer (seq_timer),
    .seq_sweep (seq_sweep),
    .lat_addr  (lat_addr),
    .lat_data  (lat_data)
);

// File: tb/bytewrite_mem_ctrl_tb.sv
`timescale 1ns/1ps
module bytewrite_mem_ctrl_tb;
    localparam int AW = 9;
    localparam int DW = 8;
    localparam int FLT = 3;
    localparam int SP = 6;
    localparam int LP = 15;
    localparam int DEPTH = 1 << AW;

    logic clk = 0, rst_n = 0;
    logic ce_n = 1, oe_n = 1, we_n = 1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data_in = '0;
    logic [DW-1:0] data_out;
    logic data_oe;
    logic long_mode = 0, clear_req = 0, wr_inhibit = 0, power_good = 1;

    int total = 0, bad = 0;
    string cur_req = "R2";
    int cycles = 0;

    bytewrite_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .FILTER_CYCLES(FLT),
        .SHORT_PHASE(SP), .LONG_PHASE(LP)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .long_mode(long_mode), .clear_req(clear_req), .wr_inhibit(wr_inhibit),
        .power_good(power_good));

    always #10 clk = ~clk;

    // behavioural reference model
    int m_mem [DEPTH];
    int m_cnt, m_kind, m_rem, m_ph, m_a, m_d, m_swp;
    bit m_clr_prev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 255;
            m_cnt = 0; m_kind = 0; m_rem = 0; m_ph = 0;
            m_a = 0; m_d = 0; m_swp = 0; m_clr_prev = 0;
        end else begin
            bit act, acc, ok;
            act = !ce_n && !we_n;
            acc = act && (m_cnt == FLT - 1);
            m_cnt = act ? ((m_cnt < FLT) ? m_cnt + 1 : m_cnt) : 0;
            ok = power_good && !wr_inhibit;
            if (m_kind == 1) begin
                m_rem--;
                if (m_rem == m_ph) m_mem[m_a] = 255;
                if (m_rem == 0) begin m_mem[m_a] = m_d; m_kind = 0; end
            end else if (m_kind == 2) begin
                m_mem[m_swp] = 255;
                m_swp++;
                if (m_swp == DEPTH) m_kind = 0;
            end else if (ok && acc) begin
                m_kind = 1; m_a = int'(addr); m_d = int'(data_in);
                m_ph = long_mode ? LP : SP; m_rem = 2 * m_ph;
            end else if (ok && clear_req && !m_clr_prev) begin
                m_kind = 2; m_swp = 0; m_d = 255;
            end
            m_clr_prev = clear_req;
        end
    end

    task automatic chk(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the edges
    always @(negedge clk) begin
        #4;
        if (rst_n) begin
            int exp_out, exp_oe;
            exp_oe = (!ce_n && !oe_n && we_n) ? 1 : 0;
            if (exp_oe == 0) exp_out = 0;
            else if (m_kind != 0) exp_out = ((m_d & 128) != 0) ? 0 : 128;
            else exp_out = m_mem[int'(addr)];
            chk({cur_req, " oe"}, int'(data_oe), exp_oe);
            chk({cur_req, " data"}, int'(data_out), exp_out);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog got=%0d exp<=150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic bus_idle();
        @(negedge clk);
        ce_n = 1; oe_n = 1; we_n = 1;
    endtask

    task automatic wr_pulse(int a, int d, int lowc);
        @(negedge clk);
        ce_n = 0; oe_n = 1; we_n = 0; addr = AW'(a); data_in = DW'(d);
        repeat (lowc) @(negedge clk);
        we_n = 1; ce_n = 1; addr = ~addr; data_in = ~data_in;
    endtask

    task automatic rd(string req, int a, int exp);
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; addr = AW'(a);
        #4;
        chk(req, int'(data_out), exp);
    endtask

    task automatic idle_wait(int n);
        bus_idle();
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R2";
        rd("R2", 0, 255);
        rd("R2", 511, 255);
        @(negedge clk); oe_n = 1; #4;
        chk("R1", int'(data_oe), 0);
        chk("R1", int'(data_out), 0);

        cur_req = "R3";
        wr_pulse(5, 8'h3C, FLT - 1);
        idle_wait(2);
        rd("R3", 5, 255);
        wr_pulse(5, 8'h3C, FLT);
        cur_req = "R6";
        rd("R6", 200, 8'h80);
        idle_wait(2 * SP);
        cur_req = "R5";
        rd("R5", 5, 8'h3C);

        // long pulse: capture at accept edge, bus changes after
        cur_req = "R4";
        @(negedge clk);
        ce_n = 0; oe_n = 1; we_n = 0; addr = 9'd17; data_in = 8'hA5;
        repeat (FLT) @(negedge clk);
        addr = 9'd18; data_in = 8'h11;
        repeat (4) @(negedge clk);
        we_n = 1; ce_n = 1;
        idle_wait(2 * SP + 2);
        rd("R4", 17, 8'hA5);
        rd("R3", 18, 255);

        // write during busy is ignored
        cur_req = "R8";
        wr_pulse(30, 8'h00, FLT);
        wr_pulse(31, 8'h77, FLT);
        @(negedge clk); clear_req = 1;
        @(negedge clk); clear_req = 0;
        idle_wait(2 * SP + 2);
        rd("R8", 30, 0);
        rd("R8", 31, 255);
        rd("R8", 17, 8'hA5);

        // long timing
        cur_req = "R7";
        long_mode = 1;
        wr_pulse(40, 8'hC3, FLT);
        long_mode = 0;
        idle_wait(2 * SP + 2);
        rd("R7", 40, 8'h00);
        idle_wait(2 * (LP - SP));
        rd("R7", 40, 8'hC3);

        // protection
        cur_req = "R9";
        wr_inhibit = 1;
        wr_pulse(50, 8'h12, FLT);
        @(negedge clk); clear_req = 1;
        @(negedge clk); clear_req = 0;
        idle_wait(3);
        wr_inhibit = 0;
        rd("R9", 50, 255);
        rd("R9", 40, 8'hC3);
        power_good = 0;
        wr_pulse(51, 8'h34, FLT);
        idle_wait(3);
        power_good = 1;
        rd("R9", 51, 255);

        // chip clear
        cur_req = "R10";
        bus_idle();
        clear_req = 1;
        @(negedge clk); clear_req = 0;
        rd("R10", 40, 8'h00);
        idle_wait(DEPTH + 2);
        rd("R10", 5, 255);
        rd("R10", 17, 255);
        rd("R10", 30, 255);
        rd("R10", 40, 255);

        cur_req = "R1";
        rd("R1", 0, 255);
        @(negedge clk); we_n = 0; ce_n = 1; #4;
        chk("R1", int'(data_oe), 0);
        bus_idle();
        repeat (2) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule